// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block is a small bank of byte-wide control registers on a simple register bus. A write never replaces a whole register. One bus bit chooses the operation. With that bit low, the bits that are 1 in the write data become set. With it high, those bits become cleared. All other bits keep their value. Software can therefore change one reset line or one pin without first reading the register back.

The bank drives several groups of outputs:
- five peripheral reset lines;
- UART routing and card-mode selects;
- a hibernate request and three wake enables;
- direction and level for five general-purpose pins;
- an optional 8-bit port that reuses address pins as plain I/O.

A 7-bit PWM generator shares the bank. Its match value is written directly, and its output can be enabled on any of three pins. A read returns the module version byte, a capability byte or live pin levels. It never returns the control values that were written.

Top module: `scr_bank`

## Requirements
- R1: After synchronous reset, every stored register is zero. All reset, routing, hibernate, wake, pin-enable, pin-level and port outputs are then low.
- R2: A selected write with `bus_clr`=0 sets the bits that are 1 in `bus_wdata`. Other bits keep their value. The result is visible on the outputs in the cycle after the write edge.
- R3: A selected write with `bus_clr`=1 clears the bits that are 1 in `bus_wdata`. Other bits keep their value.
- R4: Index 3 holds the PWM match value. It takes `bus_wdata[6:0]` directly, whatever `bus_clr` is, and bit 7 is dropped.
- R5: Index 0 is the reset register. Its bits map to the outputs as follows: bit 0 to `rst_global`, bit 2 to `rst_codec`, bit 3 to `rst_phy`, bit 4 to `rst_wlan` and bit 5 to `rst_bt`.
- R6: A read of index 0 returns the parameter `VERSION` (default 8'h50). A read of index 1 returns the parameter `CAPS` (default 8'h0F).
- R7: Index 1 is the feature register. Its bits map as follows:
  - bit 0 drives `uart_to_edge`, bit 1 drives `uart_to_bt` and bit 2 drives `card_mode`;
  - bit 3 enables the address-pin port;
  - bits 4 to 6 gate the PWM onto `pwm_pins[0]` to `pwm_pins[2]`.
- R8: Index 2 is the hibernate register. Bit 0 drives `hib_req`, and bits 3:1 drive `wake_en[2:0]`.
- R9: Index 4 bits 4:0 drive `gp_oe` (1 = output), and index 5 bits 4:0 drive `gp_out`. A read of index 4 returns `{3'b0, gp_in}`.
- R10: Index 6 stores the port byte, and `ttl_oe` equals feature bit 3. While that bit is set, `ttl_out` carries the stored byte and a read of index 6 returns `ttl_in`. While it is clear, `ttl_out` is zero and the read returns zero.
- R11: A 7-bit counter runs freely from zero after reset. The PWM signal is high while the count is below the match value. Over any 128 consecutive cycles it is high exactly match-value times, so a match of 0 keeps it low.
- R12: With `bus_sel` low, a write has no effect. Reads of indices 2, 3, 5 and 7 return zero, and `bus_rdata` is zero whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 3 | Register index |
| bus_clr | input | 1 | Write type: 0 set marked bits, 1 clear marked bits |
| bus_wdata | input | 8 | Write data / bit mask |
| bus_rdata | output | 8 | Read data (combinational) |
| rst_global | output | 1 | Global reset request |
| rst_codec | output | 1 | Audio/touch codec reset |
| rst_phy | output | 1 | Ethernet PHY reset |
| rst_wlan | output | 1 | WLAN reset |
| rst_bt | output | 1 | Bluetooth reset |
| uart_to_edge | output | 1 | Route UART to edge connector |
| uart_to_bt | output | 1 | Route UART to Bluetooth |
| card_mode | output | 1 | Card mode, UART disabled |
| hib_req | output | 1 | Hibernate request |
| wake_en | output | 3 | Wake enables: touch, external line, interrupt pin |
| pwm_pins | output | 3 | Gated PWM on three pins |
| gp_in | input | 5 | Live levels of general-purpose pins |
| gp_out | output | 5 | Drive levels of general-purpose pins |
| gp_oe | output | 5 | Output enables of general-purpose pins |
| ttl_in | input | 8 | Levels of the low address pins used as inputs |
| ttl_out | output | 8 | Levels for the high address pins used as outputs |
| ttl_oe | output | 1 | Address-pin port enable |

## Verification
The hardest behaviour to reach from the ports is the PWM duty. The PWM counter is internal and runs freely, so the bench cannot know its phase. The stimulus therefore counts high samples over a whole 128-cycle window, which gives a result that does not depend on phase. It does this for match values 0, 32 and 127, and with each pin gate on or off. The set/clear behaviour is built up through sequences in which a later write must leave earlier bits unchanged. Each of these sequences is checked on the outputs after every write.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int DW    = 8;
    localparam int PWM_W = 7;
    localparam int GP_N  = 5;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL = 3'd0,
        IDX_FEAT = 3'd1,
        IDX_HIB  = 3'd2,
        IDX_PWM  = 3'd3,
        IDX_DIR  = 3'd4,
        IDX_LVL  = 3'd5,
        IDX_TTL  = 3'd6,
        IDX_NONE = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [DW-1:0]    ctrl;
        logic [DW-1:0]    feat;
        logic [DW-1:0]    hib;
        logic [PWM_W-1:0] pwm;
        logic [GP_N-1:0]  dir;
        logic [GP_N-1:0]  lvl;
        logic [DW-1:0]    ttl;
    } regs_t;

    // Bit positions inside the feature register that other logic decodes
    localparam int FEAT_TTL_EN = 3;
    localparam int FEAT_PWM_LO = 4;

    function automatic logic [DW-1:0] set_or_clear(
        input logic [DW-1:0] old_v,
        input logic [DW-1:0] mask,
        input logic          clr
    );
        return clr ? (old_v & ~mask) : (old_v | mask);
    endfunction

endpackage

// File: rtl/scr_regfile.sv
module scr_regfile
    import scr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           wr,
    input  reg_idx_e       idx,
    input  logic           clr,
    input  logic [DW-1:0]  wdata,
    output regs_t          regs
);

    logic          do_wr;
    logic [DW-1:0] dir_new;
    logic [DW-1:0] lvl_new;

    assign do_wr   = sel && wr;
    assign dir_new = set_or_clear(DW'(regs.dir), wdata, clr);
    assign lvl_new = set_or_clear(DW'(regs.lvl), wdata, clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (do_wr) begin
            case (idx)
                IDX_CTRL: regs.ctrl <= set_or_clear(regs.ctrl, wdata, clr);
                IDX_FEAT: regs.feat <= set_or_clear(regs.feat, wdata, clr);
                IDX_HIB:  regs.hib  <= set_or_clear(regs.hib, wdata, clr);
                IDX_PWM:  regs.pwm  <= wdata[PWM_W-1:0];
                IDX_DIR:  regs.dir  <= dir_new[GP_N-1:0];
                IDX_LVL:  regs.lvl  <= lvl_new[GP_N-1:0];
                IDX_TTL:  regs.ttl  <= set_or_clear(regs.ttl, wdata, clr);
                default:  ;
            endcase
        end
    end

    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (do_wr && !clr && idx == IDX_FEAT) |=> ((regs.feat & $past(regs.feat)) == $past(regs.feat))); // R2
    AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (do_wr && clr && idx == IDX_HIB) |=> ((regs.hib & $past(wdata)) == '0)); // R3
    AST_PWM_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (do_wr && idx == IDX_PWM) |=> (regs.pwm == $past(wdata[PWM_W-1:0]))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !do_wr |=> $stable(regs)); // R12

endmodule

// File: rtl/scr_pwm.sv
module scr_pwm
    import scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PWM_W-1:0] match,
    output logic             pwm
);

    localparam logic [PWM_W-1:0] CNT_MAX = '1;

    logic [PWM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign pwm = (cnt < match);

    AST_ZERO_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
        (match == '0) |-> !pwm); // R11
    AST_FULL_MATCH_HIGH: assert property (@(posedge clk) disable iff (rst)
        (match == CNT_MAX && cnt != CNT_MAX) |-> pwm); // R11
    AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == $past(cnt) + 1'b1)); // R11

endmodule

// File: rtl/scr_readmux.sv
module scr_readmux
    import scr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h50,
    parameter logic [7:0] CAPS    = 8'h0F
) (
    input  logic            sel,
    input  logic            wr,
    input  reg_idx_e        idx,
    input  logic [GP_N-1:0] gp_in,
    input  logic            ttl_en,
    input  logic [DW-1:0]   ttl_in,
    output logic [DW-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (idx)
                IDX_CTRL: rdata = VERSION;
                IDX_FEAT: rdata = CAPS;
                IDX_DIR:  rdata = DW'(gp_in);
                IDX_TTL:  rdata = ttl_en ? ttl_in : '0;
                default:  rdata = '0;
            endcase
        end
    end

    always_comb begin
        if (!(sel && !wr)) begin
            AST_RD_IDLE_ZERO: assert (rdata == '0); // R12
        end
    end

endmodule

// File: rtl/scr_bank.sv
module scr_bank
    import scr_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h50,
    parameter logic [7:0] CAPS    = 8'h0F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_idx,
    input  logic       bus_clr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       rst_global,
    output logic       rst_codec,
    output logic       rst_phy,
    output logic       rst_wlan,
    output logic       rst_bt,
    output logic       uart_to_edge,
    output logic       uart_to_bt,
    output logic       card_mode,
    output logic       hib_req,
    output logic [2:0] wake_en,
    output logic [2:0] pwm_pins,
    input  logic [4:0] gp_in,
    output logic [4:0] gp_out,
    output logic [4:0] gp_oe,
    input  logic [7:0] ttl_in,
    output logic [7:0] ttl_out,
    output logic       ttl_oe
);

    localparam int PWM_PINS = 3;

    regs_t    regs;
    reg_idx_e idx;
    logic     pwm_raw;
    logic     unused_bits;

    assign idx = reg_idx_e'(bus_idx);

    scr_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .idx   (idx),
        .clr   (bus_clr),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    scr_pwm u_pwm (
        .clk   (clk),
        .rst   (rst),
        .match (regs.pwm),
        .pwm   (pwm_raw)
    );

    scr_readmux #(.VERSION(VERSION), .CAPS(CAPS)) u_rd (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .idx    (idx),
        .gp_in  (gp_in),
        .ttl_en (regs.feat[FEAT_TTL_EN]),
        .ttl_in (ttl_in),
        .rdata  (bus_rdata)
    );

    assign rst_global   = regs.ctrl[0];
    assign rst_codec    = regs.ctrl[2];
    assign rst_phy      = regs.ctrl[3];
    assign rst_wlan     = regs.ctrl[4];
    assign rst_bt       = regs.ctrl[5];

    assign uart_to_edge = regs.feat[0];
    assign uart_to_bt   = regs.feat[1];
    assign card_mode    = regs.feat[2];

    assign hib_req      = regs.hib[0];
    assign wake_en      = regs.hib[3:1];

    for (genvar p = 0; p < PWM_PINS; p++) begin : g_pwm_gate
        assign pwm_pins[p] = pwm_raw & regs.feat[FEAT_PWM_LO + p];
    end

    assign gp_oe   = regs.dir;
    assign gp_out  = regs.lvl;

    assign ttl_oe  = regs.feat[FEAT_TTL_EN];
    assign ttl_out = ttl_oe ? regs.ttl : '0;

    assign unused_bits = ^{regs.ctrl[7:6], regs.ctrl[1], regs.feat[7], regs.hib[7:4]};

    AST_PORT_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ttl_oe |-> (ttl_out == '0)); // R10
    AST_PWM_GATED: assert property (@(posedge clk) disable iff (rst)
        !pwm_raw |-> (pwm_pins == '0)); // R7

endmodule

// File: tb/scr_bank_tb.sv
module scr_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_wr, bus_clr;
    logic [2:0] bus_idx;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rst_global, rst_codec, rst_phy, rst_wlan, rst_bt;
    logic       uart_to_edge, uart_to_bt, card_mode, hib_req;
    logic [2:0] wake_en, pwm_pins;
    logic [4:0] gp_in, gp_out, gp_oe;
    logic [7:0] ttl_in, ttl_out;
    logic       ttl_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scr_bank dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_idx(bus_idx),
        .bus_clr(bus_clr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_global(rst_global), .rst_codec(rst_codec), .rst_phy(rst_phy),
        .rst_wlan(rst_wlan), .rst_bt(rst_bt), .uart_to_edge(uart_to_edge),
        .uart_to_bt(uart_to_bt), .card_mode(card_mode), .hib_req(hib_req),
        .wake_en(wake_en), .pwm_pins(pwm_pins), .gp_in(gp_in), .gp_out(gp_out),
        .gp_oe(gp_oe), .ttl_in(ttl_in), .ttl_out(ttl_out), .ttl_oe(ttl_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic clr, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_clr = clr; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_clr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic count_pwm(input int pin, output int highs);
        highs = 0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (pwm_pins[pin]) highs++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1", "reset outputs", {rst_global, rst_codec, rst_phy, rst_wlan, rst_bt,
              uart_to_edge, uart_to_bt, card_mode, hib_req, wake_en, pwm_pins}, 0);
        check("R1", "gp_oe/gp_out", {gp_oe, gp_out}, 0);
        check("R1", "ttl port", {ttl_oe, ttl_out}, 0);
        rd_reg(3'd0, d); check("R6", "version read", d, 8'h50);
        rd_reg(3'd1, d); check("R6", "caps read", d, 8'h0F);
    endtask

    task automatic t_setclr;
        wr_reg(3'd1, 1'b0, 8'h05);
        check("R7", "feat 05 routing", {card_mode, uart_to_bt, uart_to_edge}, 3'b101);
        wr_reg(3'd1, 1'b0, 8'h02);
        check("R2", "set keeps bits", {card_mode, uart_to_bt, uart_to_edge}, 3'b111);
        wr_reg(3'd1, 1'b1, 8'h05);
        check("R3", "clear marked bits", {card_mode, uart_to_bt, uart_to_edge}, 3'b010);
        wr_reg(3'd1, 1'b1, 8'h02);
    endtask

    task automatic t_ctrl;
        logic [7:0] d;
        wr_reg(3'd0, 1'b0, 8'hFF);
        check("R5", "all resets set", {rst_global, rst_codec, rst_phy, rst_wlan, rst_bt}, 5'b11111);
        wr_reg(3'd0, 1'b1, 8'h04);
        check("R5", "codec cleared", {rst_global, rst_codec, rst_phy, rst_wlan, rst_bt}, 5'b10111);
        wr_reg(3'd0, 1'b1, 8'h21);
        check("R5", "global/bt cleared", {rst_global, rst_codec, rst_phy, rst_wlan, rst_bt}, 5'b00110);
        rd_reg(3'd0, d); check("R6", "version after writes", d, 8'h50);
        wr_reg(3'd0, 1'b1, 8'hFF);
    endtask

    task automatic t_hib;
        logic [7:0] d;
        wr_reg(3'd2, 1'b0, 8'h0F);
        check("R8", "hib all set", {wake_en, hib_req}, 4'b1111);
        wr_reg(3'd2, 1'b1, 8'h0A);
        check("R8", "hib partial clear", {wake_en, hib_req}, 4'b0101);
        rd_reg(3'd2, d); check("R12", "hib reads zero", d, 0);
    endtask

    task automatic t_pwm;
        int h;
        logic [7:0] d;
        wr_reg(3'd1, 1'b0, 8'h10);
        count_pwm(0, h); check("R11", "match 0 duty", h, 0);
        wr_reg(3'd3, 1'b1, 8'hA0);
        count_pwm(0, h); check("R4", "match 0x20 via clr write", h, 32);
        count_pwm(1, h); check("R7", "pin1 gated off", h, 0);
        wr_reg(3'd3, 1'b0, 8'hFF);
        count_pwm(0, h); check("R11", "match 127 duty", h, 127);
        wr_reg(3'd3, 1'b0, 8'h81);
        count_pwm(0, h); check("R4", "bit7 dropped match 1", h, 1);
        rd_reg(3'd3, d); check("R12", "pwm reads zero", d, 0);
        wr_reg(3'd1, 1'b1, 8'h10);
        wr_reg(3'd1, 1'b0, 8'h40);
        wr_reg(3'd3, 1'b0, 8'h40);
        count_pwm(2, h); check("R7", "pin2 duty 64", h, 64);
        count_pwm(0, h); check("R7", "pin0 gated off", h, 0);
        wr_reg(3'd1, 1'b1, 8'h40);
    endtask

    task automatic t_gpio;
        logic [7:0] d;
        wr_reg(3'd4, 1'b0, 8'hFF);
        check("R9", "dir all out", gp_oe, 5'b11111);
        wr_reg(3'd4, 1'b1, 8'h0A);
        check("R9", "dir clear", gp_oe, 5'b10101);
        wr_reg(3'd5, 1'b0, 8'h13);
        check("R9", "level set", gp_out, 5'b10011);
        gp_in = 5'b01101;
        rd_reg(3'd4, d); check("R9", "pin level read", d, 8'h0D);
        gp_in = 5'b10010;
        rd_reg(3'd4, d); check("R9", "pin level read 2", d, 8'h12);
        rd_reg(3'd5, d); check("R12", "level reg reads zero", d, 0);
    endtask

    task automatic t_ttl;
        logic [7:0] d;
        ttl_in = 8'h5A;
        wr_reg(3'd6, 1'b0, 8'hC3);
        check("R10", "port off out", {ttl_oe, ttl_out}, 0);
        rd_reg(3'd6, d); check("R10", "port off read", d, 0);
        wr_reg(3'd1, 1'b0, 8'h08);
        check("R10", "port on out", {ttl_oe, ttl_out}, {1'b1, 8'hC3});
        rd_reg(3'd6, d); check("R10", "port on read", d, 8'h5A);
        wr_reg(3'd6, 1'b1, 8'h81);
        check("R3", "port clear", ttl_out, 8'h42);
    endtask

    task automatic t_nosel;
        logic [7:0] d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_idx = 3'd0; bus_clr = 1'b0; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R12", "unselected write ignored", {rst_global, rst_codec, rst_phy, rst_wlan, rst_bt}, 0);
        check("R12", "idle rdata zero", bus_rdata, 0);
        rd_reg(3'd7, d); check("R12", "index 7 reads zero", d, 0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_idx = '0; bus_clr = 1'b0;
        bus_wdata = '0; gp_in = '0; ttl_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_ctrl();
        t_hib();
        t_pwm();
        t_gpio();
        t_ttl();
        t_nosel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule